// File: doc/BRIEF.md
# Clock-Hand Page Victim Selector

This block picks which physical frame to reclaim when a new page has to be brought into memory. It keeps a referenced flag and a dirty flag for each of `N_FRAMES` frames, a set of frames that are currently free, and a hand pointer that moves around the frame table in circular order. The hand keeps its position from one selection to the next, so each search starts where the previous one stopped.

A selection request is served from the free set first, with no scan. Only when no frame is free does the hand sweep the table. Two sweep policies are available:
- **Second-chance sweep.** Frames with the referenced flag set are cleared and skipped. The first frame with the flag clear is taken.
- **Class sweep.** Each frame is ranked by its two flags. The first frame of the best rank found from the hand is taken, and no flags are changed.

The chosen frame index is returned together with a one-cycle done strobe. Other inputs record page accesses, clear every referenced flag at once (the periodic aging tick), and return the frames of an exiting process to the free set.

Top module: `vs_victim_sel`

## Requirements
- R1: After reset, `sel_ready` is 1 and `done` is 0. All referenced and dirty flags are 0, the hand is at frame 0, and every frame is in the free set.
- R2: While the free set is not empty, an accepted request returns the lowest-numbered free frame. `done` is high in the cycle after acceptance. That frame leaves the free set and the hand does not move.
- R3: Second-chance sweep (`sel_nru`=0) looks at one frame per cycle, starting at the hand. A frame with the referenced flag set has the flag cleared and is skipped. The first frame with the flag clear is returned and the hand moves one past it. `done` is high in the cycle after the k-th examination edge, where k frames were examined, and `sel_ready` is high again in that same cycle.
- R4: If every frame has its referenced flag set, the second-chance sweep returns the frame where the hand started, after N_FRAMES+1 examinations. It leaves every referenced flag clear.
- R5: Class sweep (`sel_nru`=1) ranks each frame as class = 2*referenced + dirty. It returns the first frame of the lowest class present, in circular order from the hand. The hand moves to one past the returned frame. No referenced or dirty flag is changed.
- R6: The class sweep examines one frame per cycle. It stops at the first class-0 frame, j+1 cycles in when that frame is at offset j from the hand. Otherwise it completes a full lap of N_FRAMES cycles.
- R7: An access (`acc_valid`) sets the referenced flag of `acc_frame`, and also sets its dirty flag when `acc_write` is 1. `ref_clear` clears every referenced flag and leaves the dirty flags as they are.
- R8: `free_valid` puts `free_frame` into the free set and clears both of its flags. The next request then takes a frame from the free set.
- R9: `sel_ready` is 0 while a sweep is in progress. A request presented during that time is ignored and produces no extra `done`.
- R10: The hand keeps its value between requests. It changes only during a sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Record an access to `acc_frame` |
| acc_frame | input | $clog2(N_FRAMES) | Frame that was accessed |
| acc_write | input | 1 | The access was a write (sets the dirty flag) |
| ref_clear | input | 1 | Clear all referenced flags |
| free_valid | input | 1 | Return `free_frame` to the free set |
| free_frame | input | $clog2(N_FRAMES) | Frame being returned |
| sel_valid | input | 1 | Request a victim frame |
| sel_nru | input | 1 | 0: second-chance sweep, 1: class sweep |
| sel_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle strobe: `victim` is valid |
| victim | output | $clog2(N_FRAMES) | Chosen frame index |

## Verification
The main function is exercised with the following patterns, each tied to a specific failure it exposes:
- **Draining a full free set.** Shows whether the free set is used in index order ahead of any sweep.
- **Referenced flags only before the first clear frame.** Separates the second-chance skipping from a plain FIFO pick.
- **All flags set.** Shows the FIFO degenerate case and the N_FRAMES+1 latency.
- **Class sweep with a class-0 frame mid-lap.** Shows the early stop.
- **Class sweep with only class-1 frames as the best.** Shows the full lap and the circular "first from the hand" tie rule.
- **Class sweep repeated on the same state.** A second sweep on unchanged flags would pick differently if the first sweep had altered the referenced flags.
- **Requests held high during a long sweep.** Shows whether they are ignored.

// File: rtl/vs_pkg.sv
package vs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CLOCK = 2'd1,
      ST_NRU   = 2'd2
   } sweep_state_e;

   localparam logic [1:0] CLS_WORST = 2'b11;
endpackage

// File: rtl/vs_frame_bits.sv
module vs_frame_bits #(
   parameter int N_FRAMES = 16,
   localparam int IW = $clog2(N_FRAMES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic [IW-1:0]       acc_frame,
   input  logic                acc_write,
   input  logic                ref_clear,
   input  logic                sweep_clr,
   input  logic [IW-1:0]       sweep_frame,
   input  logic                free_valid,
   input  logic [IW-1:0]       free_frame,
   output logic [N_FRAMES-1:0] ref_bits,
   output logic [N_FRAMES-1:0] mod_bits
);
   for (genvar i = 0; i < N_FRAMES; i++) begin : g_frame
      logic hit_acc, hit_sweep, hit_free;
      logic r_q, m_q;

      assign hit_acc   = acc_valid  && (acc_frame   == IW'(i));
      assign hit_sweep = sweep_clr  && (sweep_frame == IW'(i));
      assign hit_free  = free_valid && (free_frame  == IW'(i));

      // an access in the same cycle wins over any clearing source
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q <= 1'b0;
            m_q <= 1'b0;
         end else begin
            if (hit_acc)
               r_q <= 1'b1;
            else if (ref_clear || hit_sweep || hit_free)
               r_q <= 1'b0;
            if (hit_acc && acc_write)
               m_q <= 1'b1;
            else if (hit_free)
               m_q <= 1'b0;
         end
      end

      assign ref_bits[i] = r_q;
      assign mod_bits[i] = m_q;
   end
endmodule

// File: rtl/vs_free_pool.sv
module vs_free_pool #(
   parameter int N_FRAMES = 16,
   localparam int IW = $clog2(N_FRAMES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          free_valid,
   input  logic [IW-1:0] free_frame,
   input  logic          take_valid,
   input  logic [IW-1:0] take_frame,
   output logic          pool_empty,
   output logic [IW-1:0] first_free
);
   logic [N_FRAMES-1:0] pool_q;
   logic [N_FRAMES-1:0] take_mask, give_mask;

   always_comb begin
      take_mask = '0;
      give_mask = '0;
      if (take_valid) take_mask[take_frame] = 1'b1;
      if (free_valid) give_mask[free_frame] = 1'b1;
   end

   // all frames start out free
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pool_q <= '1;
      else        pool_q <= (pool_q & ~take_mask) | give_mask;
   end

   // lowest set bit wins
   always_comb begin
      first_free = '0;
      for (int i = N_FRAMES - 1; i >= 0; i--)
         if (pool_q[i]) first_free = IW'(i);
   end

   assign pool_empty = (pool_q == '0);
endmodule

// File: rtl/vs_sweep_ctrl.sv
module vs_sweep_ctrl
   import vs_pkg::*;
#(
   parameter int N_FRAMES = 16,
   localparam int IW = $clog2(N_FRAMES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_valid,
   input  logic                sel_nru,
   input  logic                pool_empty,
   input  logic [IW-1:0]       first_free,
   input  logic [N_FRAMES-1:0] ref_bits,
   input  logic [N_FRAMES-1:0] mod_bits,
   output logic                sel_ready,
   output logic                done,
   output logic [IW-1:0]       victim,
   output logic                take_valid,
   output logic [IW-1:0]       take_frame,
   output logic                sweep_clr,
   output logic [IW-1:0]       sweep_frame,
   output logic [IW-1:0]       hand
);
   localparam logic [IW-1:0] LAST = IW'(N_FRAMES - 1);

   sweep_state_e  state_q;
   logic [IW-1:0] hand_q, cnt_q, best_idx_q, victim_q;
   logic [1:0]    best_cls_q;
   logic          done_q;

   logic [IW-1:0] pos, choice;
   logic [1:0]    cur_cls;
   logic          accept, clk_finish, nru_finish;

   // cnt_q stays 0 in second-chance mode, so pos is the hand there
   assign pos       = hand_q + cnt_q;
   assign cur_cls   = {ref_bits[pos], mod_bits[pos]};
   assign sel_ready = (state_q == ST_IDLE);
   assign accept    = sel_valid && sel_ready;

   always_comb begin
      take_valid = 1'b0;
      take_frame = first_free;
      sweep_clr  = 1'b0;
      clk_finish = 1'b0;
      nru_finish = 1'b0;
      choice     = (cur_cls < best_cls_q) ? pos : best_idx_q;
      case (state_q)
         ST_IDLE:  take_valid = accept && !pool_empty;
         ST_CLOCK: begin
            sweep_clr  = cur_cls[1];
            clk_finish = !cur_cls[1];
         end
         ST_NRU:   nru_finish = (cur_cls == 2'b00) || (cnt_q == LAST);
         default:  ;
      endcase
      if (clk_finish) begin
         take_valid = 1'b1;
         take_frame = hand_q;
      end
      if (nru_finish) begin
         take_valid = 1'b1;
         take_frame = choice;
      end
   end

   assign sweep_frame = hand_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         hand_q     <= '0;
         cnt_q      <= '0;
         best_cls_q <= CLS_WORST;
         best_idx_q <= '0;
         victim_q   <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (accept) begin
               if (!pool_empty) begin
                  victim_q <= first_free;
                  done_q   <= 1'b1;
               end else begin
                  state_q    <= sel_nru ? ST_NRU : ST_CLOCK;
                  cnt_q      <= '0;
                  best_cls_q <= CLS_WORST;
                  best_idx_q <= hand_q;
               end
            end
            ST_CLOCK: begin
               hand_q <= hand_q + IW'(1);
               if (clk_finish) begin
                  victim_q <= hand_q;
                  done_q   <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            ST_NRU: begin
               if (nru_finish) begin
                  victim_q <= choice;
                  hand_q   <= choice + IW'(1);
                  done_q   <= 1'b1;
                  state_q  <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q + IW'(1);
                  if (cur_cls < best_cls_q) begin
                     best_cls_q <= cur_cls;
                     best_idx_q <= pos;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done   = done_q;
   assign victim = victim_q;
   assign hand   = hand_q;
endmodule

// File: rtl/vs_victim_sel.sv
module vs_victim_sel #(
   parameter int N_FRAMES = 16,
   localparam int IW = $clog2(N_FRAMES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_valid,
   input  logic [IW-1:0] acc_frame,
   input  logic          acc_write,
   input  logic          ref_clear,
   input  logic          free_valid,
   input  logic [IW-1:0] free_frame,
   input  logic          sel_valid,
   input  logic          sel_nru,
   output logic          sel_ready,
   output logic          done,
   output logic [IW-1:0] victim
);
   if (N_FRAMES < 2 || (N_FRAMES & (N_FRAMES - 1)) != 0) begin : g_bad_frames
      $error("N_FRAMES must be a power of two and at least 2");
   end

   logic [N_FRAMES-1:0] ref_bits, mod_bits;
   logic                pool_empty, take_valid, sweep_clr;
   logic [IW-1:0]       first_free, take_frame, sweep_frame, hand;

   vs_frame_bits #(.N_FRAMES(N_FRAMES)) u_bits (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
      .ref_clear(ref_clear),
      .sweep_clr(sweep_clr), .sweep_frame(sweep_frame),
      .free_valid(free_valid), .free_frame(free_frame),
      .ref_bits(ref_bits), .mod_bits(mod_bits)
   );

   vs_free_pool #(.N_FRAMES(N_FRAMES)) u_pool (
      .clk(clk), .rst_n(rst_n),
      .free_valid(free_valid), .free_frame(free_frame),
      .take_valid(take_valid), .take_frame(take_frame),
      .pool_empty(pool_empty), .first_free(first_free)
   );

   vs_sweep_ctrl #(.N_FRAMES(N_FRAMES)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sel_valid(sel_valid), .sel_nru(sel_nru),
      .pool_empty(pool_empty), .first_free(first_free),
      .ref_bits(ref_bits), .mod_bits(mod_bits),
      .sel_ready(sel_ready), .done(done), .victim(victim),
      .take_valid(take_valid), .take_frame(take_frame),
      .sweep_clr(sweep_clr), .sweep_frame(sweep_frame),
      .hand(hand)
   );
endmodule

// File: rtl/vs_victim_sel_chk.sv
module vs_victim_sel_chk #(
   parameter int N_FRAMES = 16,
   localparam int IW = $clog2(N_FRAMES)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sel_valid,
   input logic                sel_ready,
   input logic                done,
   input logic                acc_valid,
   input logic                acc_write,
   input logic [IW-1:0]       acc_frame,
   input logic                ref_clear,
   input logic                free_valid,
   input logic                pool_empty,
   input logic [IW-1:0]       hand,
   input logic [N_FRAMES-1:0] ref_bits,
   input logic [N_FRAMES-1:0] mod_bits
);
   p_pool_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid && sel_ready && !pool_empty |=> done);

   p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> sel_ready);

   p_ref_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ref_clear && !acc_valid) |-> (ref_bits == '0));

   p_write_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_valid && acc_write && !free_valid) |-> mod_bits[$past(acc_frame)]);

   p_drop_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_ready) |-> $past(sel_valid));

   p_hand_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sel_ready && !sel_valid) |-> $stable(hand));
endmodule

bind vs_victim_sel vs_victim_sel_chk #(.N_FRAMES(N_FRAMES)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .sel_valid(sel_valid), .sel_ready(sel_ready), .done(done),
   .acc_valid(acc_valid), .acc_write(acc_write), .acc_frame(acc_frame),
   .ref_clear(ref_clear), .free_valid(free_valid),
   .pool_empty(pool_empty), .hand(hand),
   .ref_bits(ref_bits), .mod_bits(mod_bits)
);

// File: tb/vs_victim_sel_tb.sv
`timescale 1ns/1ps
module vs_victim_sel_tb;
   localparam int NF = 16;
   localparam int IW = $clog2(NF);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0, ref_clear = 1'b0;
   logic free_valid = 1'b0, sel_valid = 1'b0, sel_nru = 1'b0;
   logic [IW-1:0] acc_frame = '0, free_frame = '0;
   logic sel_ready, done;
   logic [IW-1:0] victim;

   always #4 clk = ~clk;

   vs_victim_sel #(.N_FRAMES(NF)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
      .ref_clear(ref_clear), .free_valid(free_valid), .free_frame(free_frame),
      .sel_valid(sel_valid), .sel_nru(sel_nru),
      .sel_ready(sel_ready), .done(done), .victim(victim)
   );

   int n_checks = 0, n_fail = 0, cyc = 0;
   bit ref_m[NF], mod_m[NF], pool_m[NF];
   int hand_m = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle_check(input string tag);
      check(sel_ready == 1'b1, tag, int'(sel_ready), 1);
      check(done == 1'b0, tag, int'(done), 0);
   endtask

   task automatic touch(input int f, input bit wr);
      acc_valid = 1'b1; acc_frame = IW'(f); acc_write = wr;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
      ref_m[f] = 1'b1;
      if (wr) mod_m[f] = 1'b1;
      idle_check("R7 idle after access");
   endtask

   task automatic clear_refs();
      ref_clear = 1'b1;
      @(negedge clk);
      ref_clear = 1'b0;
      for (int i = 0; i < NF; i++) ref_m[i] = 1'b0;
      idle_check("R7 idle after clear");
   endtask

   task automatic give_back(input int f);
      free_valid = 1'b1; free_frame = IW'(f);
      @(negedge clk);
      free_valid = 1'b0;
      pool_m[f] = 1'b1; ref_m[f] = 1'b0; mod_m[f] = 1'b0;
      idle_check("R8 idle after free");
   endtask

   // behavioural model: decide result and latency up front, then compare each cycle
   task automatic pick(input bit nru, input int hold, input string tag);
      int exp_v, lat;
      exp_v = -1;
      lat = 0;
      for (int i = 0; i < NF; i++)
         if (pool_m[i] && exp_v < 0) exp_v = i;
      if (exp_v >= 0) begin
         pool_m[exp_v] = 1'b0;
      end else if (!nru) begin
         while (exp_v < 0) begin
            lat++;
            if (!ref_m[hand_m]) exp_v = hand_m;
            else ref_m[hand_m] = 1'b0;
            hand_m = (hand_m + 1) % NF;
         end
      end else begin
         int best, bi;
         best = 4; bi = 0; lat = NF;
         for (int j = 0; j < NF; j++) begin
            int p, c;
            p = (hand_m + j) % NF;
            c = 2 * int'(ref_m[p]) + int'(mod_m[p]);
            if (c < best) begin best = c; bi = p; end
            if (c == 0) begin lat = j + 1; break; end
         end
         exp_v = bi;
         hand_m = (bi + 1) % NF;
      end
      sel_valid = 1'b1; sel_nru = nru;
      for (int c = 0; c <= lat; c++) begin
         @(negedge clk);
         if (c >= hold) sel_valid = 1'b0;
         check(done == (c == lat), {tag, " done timing"}, int'(done), int'(c == lat));
         check(sel_ready == (c == lat), "R9 ready while busy", int'(sel_ready), int'(c == lat));
      end
      check(int'(victim) == exp_v, {tag, " victim"}, int'(victim), exp_v);
      sel_valid = 1'b0;
      @(negedge clk);
      check(done == 1'b0, "R9 no extra done", int'(done), 0);
      check(sel_ready == 1'b1, "R9 ready after done", int'(sel_ready), 1);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NF; i++) begin
         ref_m[i] = 1'b0; mod_m[i] = 1'b0; pool_m[i] = 1'b1;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle_check("R1 reset state");

      // R2: drain the full free set in index order
      for (int i = 0; i < NF; i++) pick(1'b0, 0, "R2 pool");

      // R3: skip referenced frames 0..3 from hand 0
      touch(0, 1'b0); touch(1, 1'b0); touch(2, 1'b0); touch(3, 1'b1);
      pick(1'b0, 0, "R3 second chance");
      pick(1'b0, 0, "R10 hand persists");

      // R4 and R9: all referenced, requests held high while busy
      for (int i = 0; i < NF; i++) touch(i, 1'b0);
      pick(1'b0, 4, "R4 all referenced");
      pick(1'b0, 0, "R4 flags left clear");

      // R6: class-0 frame mid-lap stops the sweep early
      clear_refs();
      for (int i = 0; i < NF; i++) if (i != 12) touch(i, 1'b0);
      pick(1'b1, 0, "R6 early stop");

      // R5: best class is 1 only; full lap, first from hand, flags kept
      touch(10, 1'b1);
      clear_refs();
      for (int i = 0; i < NF; i++) if (i != 3 && i != 10) touch(i, 1'b0);
      pick(1'b1, 0, "R5 lowest class");
      pick(1'b1, 0, "R5 flags unchanged");

      // R8: freed frames are used before any sweep
      give_back(9); give_back(2);
      pick(1'b1, 0, "R8 pool first");
      pick(1'b0, 0, "R8 pool second");
      pick(1'b0, 0, "R3 sweep after pool");
      pick(1'b1, 0, "R5 class sweep after pool");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule